// File: doc/BRIEF.md
# Four-Function Ripple ALU

This block is a purely combinational arithmetic logic unit of parametric width (4 bits by default). It computes one result from a first operand and a second operand. The second operand is either a register value or a short immediate constant. The immediate is zero-extended to the full width before it reaches the datapath.

A 2-bit operation code selects one of four functions:

- an arithmetic path, which is a ripple chain of one-bit full adders;
- bitwise AND;
- bitwise OR;
- bitwise inversion of the first operand.

Within the arithmetic path, a separate subtract control chooses between addition and subtraction. Subtraction is done on the same chain: the second operand is inverted and the lowest carry-in is forced high, which computes two's-complement subtraction.

The block has no clock and no state. A surrounding pipeline registers its outputs wherever it needs them.

Top module: `alu4_ripple`

## Requirements
- R1: With `op_sel` = 2'b00 and `sub_en` = 0, `{carry_out, result}` equals the unsigned (W+1)-bit sum of `opa` and the selected second operand.
- R2: With `op_sel` = 2'b00 and `sub_en` = 1, `result` equals `opa` minus the selected operand, modulo 2^W. `carry_out` equals the top carry of `opa` + ~operand + 1, so it is 1 exactly when `opa` >= operand, unsigned.
- R3: Results read as two's complement: 3 plus -2 (4'b0011 + 4'b1110) gives 4'b0001, and 2 minus 3 gives 4'b1111 (-1).
- R4: With `op_sel` = 2'b01, `result` is the bitwise AND of `opa` and the selected operand.
- R5: With `op_sel` = 2'b10, `result` is the bitwise OR of `opa` and the selected operand.
- R6: With `op_sel` = 2'b11, `result` is the bitwise inverse of `opa`, whatever the second operand is.
- R7: For `op_sel` other than 2'b00, `carry_out` is 0.
- R8: When `use_imm` = 1, the second operand is `imm_val` zero-extended to W bits. When `use_imm` = 0, the second operand is `opb_reg`.
- R9: `sub_en` has no effect on `result` or `carry_out` when `op_sel` is not 2'b00.
- R10: The outputs depend only on the present inputs. The same inputs give the same outputs in any order of application.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (4) | First operand |
| opb_reg | input | W (4) | Register-path second operand |
| imm_val | input | IW (3) | Immediate constant, zero-extended |
| use_imm | input | 1 | 1 selects the immediate as second operand |
| op_sel | input | 2 | 00 arith, 01 AND, 10 OR, 11 NOT opa |
| sub_en | input | 1 | 1 makes the arithmetic path subtract |
| result | output | W (4) | Function result |
| carry_out | output | 1 | Final adder carry; 0 for logic functions |

## Verification
The hardest cases to reach are those where the carry crosses every stage of the chain. These occur when an all-ones sum is pushed over by a carry-in of 1, or when a subtraction has equal operands and still produces carry-out 1. Directed vectors cover 4'b1111 + 4'b0001, 5 - 5 and 0 - 0 before the sweep.

The stimulus then applies every combination of operands, function and subtract control, on both the register path and the immediate path. In this way the zero-extended immediate also feeds each stage of the chain, including the upper bit that the immediate field cannot set.

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
  parameter int W  = 4,
  parameter int IW = 3
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb_reg,
  input  logic [IW-1:0] imm_val,
  input  logic          use_imm,
  input  logic [1:0]    op_sel,
  input  logic          sub_en,
  output logic [W-1:0]  result,
  output logic          carry_out
);
  localparam int PAD = W - IW;

  logic [W-1:0] b_sel;
  logic [W-1:0] b_add;
  logic [W-1:0] sum;
  logic [W:0]   cy;

  assign b_sel = use_imm ? {{PAD{1'b0}}, imm_val} : opb_reg;
  assign b_add = b_sel ^ {W{sub_en}};
  assign cy[0] = sub_en;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = opa[i] ^ b_add[i] ^ cy[i];
    assign cy[i+1] = (opa[i] & b_add[i]) | (cy[i] & (opa[i] ^ b_add[i]));
  end

  always_comb begin
    case (op_sel)
      2'b00:   result = sum;
      2'b01:   result = opa & b_sel;
      2'b10:   result = opa | b_sel;
      default: result = ~opa;
    endcase
  end

  assign carry_out = (op_sel == 2'b00) & cy[W];
endmodule

// File: rtl/alu4_ripple_props.sv
module alu4_ripple_props #(
  parameter int W  = 4,
  parameter int IW = 3
) (
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb_reg,
  input logic [IW-1:0] imm_val,
  input logic          use_imm,
  input logic [1:0]    op_sel,
  input logic          sub_en,
  input logic [W-1:0]  result,
  input logic          carry_out
);
  logic [W-1:0] b_ref;
  logic [W:0]   add_ref;
  logic [W:0]   sub_ref;

  always_comb begin
    b_ref   = use_imm ? W'(imm_val) : opb_reg;
    add_ref = {1'b0, opa} + {1'b0, b_ref};
    sub_ref = {1'b0, opa} + {1'b0, ~b_ref} + {{W{1'b0}}, 1'b1};
    if (op_sel == 2'b00 && !sub_en)
      p_add_r1: assert ({carry_out, result} == add_ref) else $error("add mismatch");
    if (op_sel == 2'b00 && sub_en)
      p_sub_r2: assert ({carry_out, result} == sub_ref) else $error("sub mismatch");
    if (op_sel == 2'b00 && sub_en)
      p_noborrow_r2: assert (carry_out == (opa >= b_ref)) else $error("sub carry");
    if (op_sel == 2'b01)
      p_and_r4: assert (result == (opa & b_ref)) else $error("and mismatch");
    if (op_sel == 2'b10)
      p_or_r5: assert (result == (opa | b_ref)) else $error("or mismatch");
    if (op_sel == 2'b11)
      p_not_r6: assert (result == ~opa) else $error("not mismatch");
    if (op_sel != 2'b00)
      p_logic_carry_r7: assert (!carry_out) else $error("logic carry");
  end
endmodule

bind alu4_ripple alu4_ripple_props #(.W(W), .IW(IW)) u_props (
  .opa(opa), .opb_reg(opb_reg), .imm_val(imm_val), .use_imm(use_imm),
  .op_sel(op_sel), .sub_en(sub_en), .result(result), .carry_out(carry_out)
);

// File: tb/tb_alu4_ripple.sv
`timescale 1ns/1ps
module tb_alu4_ripple;
  localparam int W  = 4;
  localparam int IW = 3;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]  opa, opb_reg, result;
  logic [IW-1:0] imm_val;
  logic          use_imm, sub_en, carry_out;
  logic [1:0]    op_sel;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu4_ripple #(.W(W), .IW(IW)) dut (
    .opa(opa), .opb_reg(opb_reg), .imm_val(imm_val), .use_imm(use_imm),
    .op_sel(op_sel), .sub_en(sub_en), .result(result), .carry_out(carry_out)
  );

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [IW-1:0] im,
                                 logic ui, logic [1:0] op, logic sb, string req);
    exp_t e;
    logic [W-1:0] bo;
    logic [W:0]   s;
    bo = ui ? {{(W-IW){1'b0}}, im} : b;
    if (sb) s = {1'b0, a} + {1'b0, ~bo} + 1;
    else    s = {1'b0, a} + {1'b0, bo};
    case (op)
      2'b00:   begin e.res = s[W-1:0]; e.cy = s[W]; end
      2'b01:   begin e.res = a & bo;   e.cy = 1'b0; end
      2'b10:   begin e.res = a | bo;   e.cy = 1'b0; end
      default: begin e.res = ~a;       e.cy = 1'b0; end
    endcase
    e.req = req;
    return e;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [IW-1:0] im,
                       logic ui, logic [1:0] op, logic sb, string req);
    @(negedge clk);
    {opa, opb_reg, imm_val, use_imm, op_sel, sub_en} = {a, b, im, ui, op, sb};
    q.push_back(model(a, b, im, ui, op, sb, req));
  endtask

  task automatic expect_fixed(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op, logic sb,
                              logic [W-1:0] r, logic c, string req);
    exp_t e;
    @(negedge clk);
    {opa, opb_reg, imm_val, use_imm, op_sel, sub_en} = {a, b, 3'd0, 1'b0, op, sb};
    e.res = r; e.cy = c; e.req = req;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res || carry_out !== e.cy) begin
        errors++;
        $display("FAIL %s: got res=%h cy=%b expected res=%h cy=%b (a=%h b=%h im=%h ui=%b op=%b sub=%b)",
                 e.req, result, carry_out, e.res, e.cy, opa, opb_reg, imm_val, use_imm, op_sel, sub_en);
      end
    end
  end

  initial begin
    {opa, opb_reg, imm_val, use_imm, op_sel, sub_en} = '0;
    // idle inputs: all zero gives zero sum, no carry (R1)
    expect_fixed(4'h0, 4'h0, 2'b00, 1'b0, 4'h0, 1'b0, "R1 idle");
    // R3 two's complement
    expect_fixed(4'b0011, 4'b1110, 2'b00, 1'b0, 4'b0001, 1'b1, "R3 3+-2");
    expect_fixed(4'd2, 4'd3, 2'b00, 1'b1, 4'b1111, 1'b0, "R3 2-3");
    // R1 full carry ripple
    expect_fixed(4'hF, 4'h1, 2'b00, 1'b0, 4'h0, 1'b1, "R1 ripple");
    // R2 equal operands
    expect_fixed(4'd5, 4'd5, 2'b00, 1'b1, 4'h0, 1'b1, "R2 5-5");
    expect_fixed(4'd0, 4'd0, 2'b00, 1'b1, 4'h0, 1'b1, "R2 0-0");
    // R4 R5 R6 R7 R9 directed
    expect_fixed(4'b1100, 4'b1010, 2'b01, 1'b1, 4'b1000, 1'b0, "R4 and");
    expect_fixed(4'b1100, 4'b1010, 2'b10, 1'b1, 4'b1110, 1'b0, "R5 or");
    expect_fixed(4'b1100, 4'b1111, 2'b11, 1'b0, 4'b0011, 1'b0, "R6 not");
    expect_fixed(4'hF, 4'hF, 2'b11, 1'b1, 4'h0, 1'b0, "R7 not carry");
    // R8 immediate zero-extended: 0x8 + imm 7 = 0xF, reg ignored
    drive(4'h8, 4'hF, 3'd7, 1'b1, 2'b00, 1'b0, "R8 imm");
    drive(4'h8, 4'h1, 3'd7, 1'b0, 2'b00, 1'b0, "R8 reg");
    // exhaustive sweep, both operand paths (R1 R2 R4 R5 R6 R7 R8 R9)
    for (int ui = 0; ui < 2; ui++)
      for (int op = 0; op < 4; op++)
        for (int sb = 0; sb < 2; sb++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              drive(W'(a), W'(b), IW'(b), ui[0], op[1:0], sb[0], "R9 sweep");
    // R10 repeat earlier vector after different history
    expect_fixed(4'b0011, 4'b1110, 2'b00, 1'b0, 4'b0001, 1'b1, "R10 repeat");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule